// File: doc/BRIEF.md
# Gated Pulse Counter with Millisecond Window

The block counts rising edges of a pulse input that is already synchronous to the system clock. Edges are counted only during a window whose length is a programmable number of milliseconds. The window is produced by a one-shot gate timer. A prescaler derives a 1 ms tick from the system clock, and a millisecond counter then runs for the requested length plus one. The gate is open for the requested number of milliseconds. It is closed during the extra tick, and the window ends when that tick expires.

A start strobe launches the mode present on the mode input. Continuous mode repeats windows back to back. It throws away the first window, because that one may be incomplete, and reports every later window. Burst mode runs one window, reports it together with its length, and stops. Free-running mode has no gate: it counts every edge from zero, and the count can be read at any time. Driving the idle mode stops everything.

Top module: `gated_pulse_counter`

## Requirements
- R1: The gate timer advances one millisecond tick every TICK_CYCLES clocks. The default is CLK_MHZ×1000, and CLK_MHZ must not exceed 65 so that the prescale value fits in 16 bits.
- R2: After a start in a timed mode, the gate output is high for exactly win_ms ticks and then low for one more tick. The window therefore ends (win_ms+1)×TICK_CYCLES clocks after the start edge, and count_valid is high in the cycle that follows that edge.
- R3: Only rising edges of pulse_in that are sampled while the gate is high increment the count. Edges during the trailing closed tick are not counted, and a level held high counts once.
- R4: At each reported window end, the count is copied to last_count, and count_valid is high for one cycle.
- R5: In continuous mode (mode=1), starting clears last_count. The first window ends without count_valid. Each window end clears the counter and opens the next window at once, with no idle cycles.
- R6: In burst mode (mode=2), the single window end raises count_valid with report_ms equal to the window length. The block then stops, the gate stays low, and no further count_valid follows.
- R7: In free-running mode (mode=3), a start clears live_count. Every rising edge then increments it with no gate, and count_valid never rises.
- R8: The mode encoding is 0 idle, 1 continuous, 2 burst, 3 free-running. The mode is taken when start is high. Mode 0 at any time stops the timers, freezes live_count, suppresses count_valid, and overrides start.
- R9: The pulse counter is CNT_W bits wide and wraps modulo 2^CNT_W.
- R10: A window length of 0 never opens the gate and reports a count of 0 after one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Synchronized pulse input |
| mode | input | 2 | 0 idle, 1 continuous, 2 burst, 3 free-running |
| start | input | 1 | One-cycle strobe launching the selected mode |
| win_ms | input | MS_W | Window length in milliseconds, captured at start |
| last_count | output | CNT_W | Count latched at the last reported window end |
| count_valid | output | 1 | One-cycle pulse when last_count is updated |
| report_ms | output | MS_W | Window length accompanying the report |
| live_count | output | CNT_W | Running pulse counter, readable at any time |
| gate_o | output | 1 | Gate timer output, high while edges are counted |

## Verification
The bench places single-cycle pulses on alternate cycles inside a window, which checks that the gated count matches the number of edges. It places edges on the last open cycle and on the first closed cycle, and a pulse held high across several cycles. These separate a gate of exactly win_ms ticks from one that is one tick off, and edge detection from level counting. Continuous runs with a different number of pulses in each window show that the first window is discarded and that the counter is cleared between windows. Free-running bursts longer than the counter range expose the wrap, and pulses sent after an idle request or with a zero-length window show that nothing is counted or reported.

// File: rtl/gated_pulse_counter.sv
module gated_pulse_counter #(
  parameter int CLK_MHZ     = 50,
  parameter int TICK_CYCLES = CLK_MHZ * 1000,
  parameter int MS_W        = 16,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic [1:0]       mode,
  input  logic             start,
  input  logic [MS_W-1:0]  win_ms,
  output logic [CNT_W-1:0] last_count,
  output logic             count_valid,
  output logic [MS_W-1:0]  report_ms,
  output logic [CNT_W-1:0] live_count,
  output logic             gate_o
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);
  localparam logic [1:0] M_IDLE = 2'd0, M_CONT = 2'd1, M_BURST = 2'd2, M_FREE = 2'd3;

  logic [1:0]       act;
  logic             skip;
  logic             pulse_q;
  logic [PRE_W-1:0] pre;
  logic [MS_W-1:0]  ms, win_q;
  logic [CNT_W-1:0] cnt;

  wire timed    = (act == M_CONT) || (act == M_BURST);
  wire tick     = timed && (pre == PRE_LAST);
  wire win_end  = tick && (ms == win_q);
  wire rise     = pulse_in && !pulse_q;
  assign gate_o = timed && (ms < win_q);
  wire count_en = rise && (gate_o || act == M_FREE);
  assign live_count = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act         <= M_IDLE;
      skip        <= 1'b0;
      pulse_q     <= 1'b0;
      pre         <= '0;
      ms          <= '0;
      win_q       <= '0;
      cnt         <= '0;
      last_count  <= '0;
      count_valid <= 1'b0;
      report_ms   <= '0;
    end else begin
      pulse_q     <= pulse_in;
      count_valid <= 1'b0;
      if (mode == M_IDLE) begin
        act <= M_IDLE;
      end else if (start) begin
        act   <= mode;
        pre   <= '0;
        ms    <= '0;
        cnt   <= '0;
        win_q <= win_ms;
        skip  <= (mode == M_CONT);
        if (mode == M_CONT) last_count <= '0;
      end else begin
        if (timed) pre <= tick ? '0 : pre + 1'b1;
        if (tick) ms <= ms + 1'b1;
        if (count_en) cnt <= cnt + 1'b1;
        if (win_end) begin
          ms   <= '0;
          skip <= 1'b0;
          if (!skip) begin
            last_count  <= cnt;
            count_valid <= 1'b1;
            report_ms   <= win_q;
          end
          if (act == M_CONT) cnt <= '0;
          else act <= M_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/gated_pulse_counter_checker.sv
module gated_pulse_counter_checker #(
  parameter int CNT_W       = 32,
  parameter int PRE_W       = 16,
  parameter int TICK_CYCLES = 50000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             start,
  input logic [1:0]       act,
  input logic             win_end,
  input logic             gate,
  input logic [PRE_W-1:0] pre,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] last_count,
  input logic             count_valid
);
  assert_prescaler_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= PRE_W'(TICK_CYCLES - 1));

  assert_closed_gate_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act != 2'd3 && !gate && !start && !win_end) |=> $stable(cnt));

  assert_valid_latches_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_valid |-> (last_count == $past(cnt) && $past(win_end)));

  assert_cont_entry_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'd1) |=> (last_count == '0 && !count_valid));

  assert_burst_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && act == 2'd2 && !start && mode != 2'd0) |=> (act == 2'd0 && !gate));

  assert_free_never_reports_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'd3 && mode != 2'd0) |=> !count_valid);

  assert_idle_is_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> (!gate && !count_valid && act == 2'd0));
endmodule

bind gated_pulse_counter gated_pulse_counter_checker #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .TICK_CYCLES(TICK_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .start(start), .act(act),
  .win_end(win_end), .gate(gate_o), .pre(pre), .cnt(live_count),
  .last_count(last_count), .count_valid(count_valid)
);

// File: tb/gated_pulse_counter_tb.sv
module gated_pulse_counter_tb;
  localparam int T  = 10;
  localparam int MW = 16;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0, pulse_in = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [MW-1:0] win_ms = '0;
  logic [CW-1:0] last_count, live_count;
  logic count_valid, gate_o;
  logic [MW-1:0] report_ms;

  int checks = 0, failures = 0, cyc = 0, base = 0;

  gated_pulse_counter #(.TICK_CYCLES(T), .MS_W(MW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .mode(mode), .start(start),
    .win_ms(win_ms), .last_count(last_count), .count_valid(count_valid),
    .report_ms(report_ms), .live_count(live_count), .gate_o(gate_o));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] m, input int w);
    @(negedge clk);
    mode = m; win_ms = MW'(w); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base = cyc;
  endtask

  task automatic pulse_at(input int k);
    while (cyc < base + k - 1) @(negedge clk);
    pulse_in = 1'b1;
    @(negedge clk);
    pulse_in = 1'b0;
  endtask

  task automatic wait_valid(input int exp_cyc, input int exp_cnt, input string tag);
    int n = 0;
    while (!count_valid && n < 500) begin @(negedge clk); n++; end
    chk(count_valid, {tag, " valid seen"}, count_valid, 1);
    chk(cyc == exp_cyc, {tag, " valid cycle"}, cyc - base, exp_cyc - base);
    chk(last_count == CW'(exp_cnt), {tag, " count"}, last_count, exp_cnt);
  endtask

  task automatic expect_no_valid(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (count_valid) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic t_reset;
    chk(last_count == 0 && live_count == 0, "R8 reset counts", last_count, 0);
    chk(!count_valid && !gate_o, "R8 reset quiet", count_valid, 0);
  endtask

  task automatic t_burst;
    do_start(2'd2, 3);
    chk(gate_o, "R2 gate opens", gate_o, 1);
    for (int k = 2; k <= 10; k += 2) pulse_at(k);
    wait_valid(base + 4 * T, 5, "R1 R2 R4 burst");
    chk(report_ms == 3, "R6 report_ms", report_ms, 3);
    @(negedge clk);
    chk(!gate_o, "R6 gate stays low", gate_o, 0);
    expect_no_valid(60, "R6 no second report");
  endtask

  task automatic t_boundary;
    do_start(2'd2, 2);
    pulse_at(1);
    while (cyc < base + 4) @(negedge clk);
    pulse_in = 1'b1;
    while (cyc < base + 9) @(negedge clk);
    pulse_in = 1'b0;
    pulse_at(20);
    pulse_at(22);
    pulse_at(28);
    wait_valid(base + 3 * T, 3, "R3 edges at gate boundary");
  endtask

  task automatic t_cont;
    do_start(2'd1, 1);
    chk(last_count == 0, "R5 entry clears last_count", last_count, 0);
    pulse_at(2); pulse_at(4);
    pulse_at(22); pulse_at(24); pulse_at(26);
    wait_valid(base + 4 * T, 3, "R5 first window skipped");
    pulse_at(43);
    wait_valid(base + 6 * T, 1, "R5 counter cleared per window");
    pulse_at(62);
    @(negedge clk);
    mode = 2'd0;
    @(negedge clk);
    begin
      logic [CW-1:0] held = live_count;
      for (int k = 66; k <= 74; k += 2) pulse_at(k);
      chk(live_count == held, "R8 idle freezes count", live_count, held);
    end
    chk(!gate_o, "R8 idle closes gate", gate_o, 0);
    expect_no_valid(40, "R8 idle no report");
  endtask

  task automatic t_zero;
    do_start(2'd2, 0);
    chk(!gate_o, "R10 gate never opens", gate_o, 0);
    pulse_at(2); pulse_at(5);
    wait_valid(base + T, 0, "R10 zero window");
  endtask

  task automatic t_free;
    do_start(2'd3, 5);
    chk(live_count == 0, "R7 free starts at zero", live_count, 0);
    for (int i = 0; i < 5; i++) pulse_at(2 + 2 * i);
    chk(live_count == 5, "R7 free count readable", live_count, 5);
    for (int i = 5; i < 18; i++) pulse_at(2 + 2 * i);
    chk(live_count == 2, "R9 counter wraps", live_count, 2);
    expect_no_valid(30, "R7 free no report");
  endtask

  task automatic t_idle_start;
    logic [CW-1:0] held;
    held = live_count;
    do_start(2'd0, 3);
    chk(!gate_o, "R8 idle overrides start gate", gate_o, 0);
    pulse_at(3); pulse_at(6);
    chk(live_count == held, "R8 idle start leaves count", live_count, held);
    expect_no_valid(50, "R8 idle start no report");
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_burst;
    t_boundary;
    t_cont;
    t_zero;
    t_free;
    t_idle_start;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule